// File: doc/BRIEF.md
# Inter-processor interrupt command dispatcher

This block sits beside one core in a system of N cores and turns a 64-bit interrupt command word into interrupt messages for other cores. Software writes the command word through a simple write port. If no earlier send is outstanding and the word is legal, the block stores it and works out the set of target cores from three things: the two-bit shorthand, the physical or logical meaning of the destination byte, and fixed or lowest-priority delivery. It then raises a request line towards each chosen core.

Every request stays up until that core pulses its accept input. A status bit in the read-back word shows that a send is in flight until the last target has accepted. Each core's logical identity (an 8-bit mask) and its current priority come in as inputs, because the registers that hold them are outside this block. Writes that arrive while busy, illegal combinations and sends that resolve to no core are refused. Each of these sets a sticky error flag.

Top module: `ipi_dispatch`

## Requirements
- R1: The read-back word keeps the fields of the last stored command at fixed positions: vector 7:0, delivery type 10:8, destination mode 11, level 14, trigger 15, shorthand 19:18, destination 63:56. Bits 13, 17:16 and 55:20 read 0. Bit 12 reads 1 while a send is pending and 0 otherwise, whatever value was written to it.
- R2: Shorthand code 0 uses the destination byte, 1 selects only the core whose index equals self_id, 2 selects every core, and 3 selects every core except self_id.
- R3: With shorthand 0 and destination mode 0, the destination byte is a core index. A value of N or more selects no core.
- R4: With shorthand 0 and destination mode 1, core i is selected when the destination byte ANDed with that core's 8-bit logical ID is nonzero.
- R5: Every delivery type other than 1 raises req_o on every selected core in the cycle after the accepted write. Each bit is held until that core's ack_i is sampled high, and it drops in the next cycle.
- R6: Delivery type 1 (lowest priority) raises exactly one request: the selected core with the smallest priority value. Among equal values the lowest core index wins.
- R7: pending_o and read-back bit 12 are 1 from the cycle after an accepted write until the cycle after the last outstanding target accepts. No new request bit appears while a send is pending.
- R8: A write while a send is pending is dropped: the stored word and the requests are unchanged, and error_o is set.
- R9: An illegal write is refused. Delivery types 3 and 7 are illegal. Type 2 with a nonzero vector is illegal. Level 0 with any type other than 5 is illegal. A refused write issues no request, leaves the stored word unchanged and sets error_o.
- R10: A legal write that resolves to no core is stored but issues no request. The status stays idle and error_o is set.
- R11: error_o, once set, stays 1 until reset.
- R12: vec_o carries the stored vector, except for delivery type 4 (non-maskable), where it is 0. type_o carries the stored delivery type code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 64 | Command word to write |
| rd_data | output | 64 | Stored command word with live status bit |
| self_id | input | IDW | Index of the owning core |
| core_lid | input | 8*N_CORES | Per-core 8-bit logical ID, core i at bits 8i+7:8i |
| core_prio | input | PRIO_W*N_CORES | Per-core priority value, smaller wins |
| req_o | output | N_CORES | Per-core interrupt request |
| ack_i | input | N_CORES | Per-core accept pulse |
| vec_o | output | 8 | Vector sent with the requests |
| type_o | output | 3 | Delivery type sent with the requests |
| pending_o | output | 1 | Send in flight |
| error_o | output | 1 | Sticky error flag |

## Verification
Several properties are checked on every cycle: an accepted request bit drops in the next cycle, no request bit is added while a send is pending, a lowest-priority send starts with a single request bit, and the error flag is sticky. Writes made while busy and illegal writes are also checked on every cycle to raise the error flag without starting a send. Other behaviour shows only in the bench scenarios, which a cycle-by-cycle reference model runs against the design: the exact target set for each shorthand and destination mode, the tie-break between equal priorities, the masking of reserved bits and the vector suppression for non-maskable sends.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [2:0] {
    DT_FIXED  = 3'd0,
    DT_LOWEST = 3'd1,
    DT_SMGMT  = 3'd2,
    DT_NMASK  = 3'd4,
    DT_RESET  = 3'd5,
    DT_BOOT   = 3'd6
  } dtype_e;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } short_e;

  localparam int CMD_W     = 64;
  localparam int VEC_LSB   = 0;
  localparam int TYPE_LSB  = 8;
  localparam int DMODE_BIT = 11;
  localparam int STAT_BIT  = 12;
  localparam int LEVEL_BIT = 14;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = 56;

  // bits software may hold; status and reserved bits are excluded
  localparam logic [CMD_W-1:0] KEEP_BITS = 64'hFF00_0000_000C_CFFF;

endpackage

// File: rtl/ipi_cmd_check.sv
module ipi_cmd_check
  import ipi_pkg::*;
(
  input  logic [2:0] dtype,
  input  logic [7:0] vec,
  input  logic       level,
  output logic       legal
);
  logic type_ok;
  logic smgmt_ok;
  logic level_ok;

  always_comb begin
    type_ok  = (dtype != 3'd3) && (dtype != 3'd7);
    smgmt_ok = (dtype != DT_SMGMT) || (vec == 8'd0);
    level_ok = level || (dtype == DT_RESET);
    legal    = type_ok && smgmt_ok && level_ok;
  end

endmodule

// File: rtl/ipi_target_resolve.sv
module ipi_target_resolve
  import ipi_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int IDW     = 2
) (
  input  logic [1:0]           shorthand,
  input  logic                 logical,
  input  logic [7:0]           dest,
  input  logic [IDW-1:0]       self_id,
  input  logic [8*N_CORES-1:0] core_lid,
  output logic [N_CORES-1:0]   targets
);
  logic [N_CORES-1:0] by_phys;
  logic [N_CORES-1:0] by_logic;
  logic [N_CORES-1:0] is_self;

  for (genvar gi = 0; gi < N_CORES; gi++) begin : g_core
    assign by_phys[gi]  = (dest == 8'(gi));
    assign by_logic[gi] = |(dest & core_lid[8*gi +: 8]);
    assign is_self[gi]  = (self_id == IDW'(gi));
  end

  always_comb begin
    unique case (shorthand)
      SH_FIELD:  targets = logical ? by_logic : by_phys;
      SH_SELF:   targets = is_self;
      SH_ALL:    targets = '1;
      default:   targets = ~is_self;
    endcase
  end

endmodule

// File: rtl/ipi_lowprio_pick.sv
module ipi_lowprio_pick #(
  parameter int N_CORES = 4,
  parameter int PRIO_W  = 4
) (
  input  logic [N_CORES-1:0]        cand,
  input  logic [PRIO_W*N_CORES-1:0] prio,
  output logic [N_CORES-1:0]        chosen
);
  logic              found;
  logic [PRIO_W-1:0] best;

  always_comb begin
    found  = 1'b0;
    best   = '0;
    chosen = '0;
    for (int i = 0; i < N_CORES; i++) begin
      // strict compare keeps the lower index on equal values
      if (cand[i] && (!found || (prio[PRIO_W*i +: PRIO_W] < best))) begin
        found     = 1'b1;
        best      = prio[PRIO_W*i +: PRIO_W];
        chosen    = '0;
        chosen[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int PRIO_W  = 4,
  localparam int IDW    = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [63:0]                 wr_data,
  output logic [63:0]                 rd_data,
  input  logic [IDW-1:0]              self_id,
  input  logic [8*N_CORES-1:0]        core_lid,
  input  logic [PRIO_W*N_CORES-1:0]   core_prio,
  output logic [N_CORES-1:0]          req_o,
  input  logic [N_CORES-1:0]          ack_i,
  output logic [7:0]                  vec_o,
  output logic [2:0]                  type_o,
  output logic                        pending_o,
  output logic                        error_o
);

  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // state
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [N_CORES-1:0] out_q, out_d;
  logic               err_q, err_d;
  logic               cmd_en;

  // decode of the incoming word
  logic               cmd_ok;
  logic [N_CORES-1:0] resolved;
  logic [N_CORES-1:0] lowest;
  logic [N_CORES-1:0] send_set;
  logic               busy;

  ipi_cmd_check u_check (
    .dtype (wr_data[TYPE_LSB +: 3]),
    .vec   (wr_data[VEC_LSB +: 8]),
    .level (wr_data[LEVEL_BIT]),
    .legal (cmd_ok)
  );

  ipi_target_resolve #(.N_CORES(N_CORES), .IDW(IDW)) u_resolve (
    .shorthand (wr_data[SH_LSB +: 2]),
    .logical   (wr_data[DMODE_BIT]),
    .dest      (wr_data[DEST_LSB +: 8]),
    .self_id   (self_id),
    .core_lid  (core_lid),
    .targets   (resolved)
  );

  ipi_lowprio_pick #(.N_CORES(N_CORES), .PRIO_W(PRIO_W)) u_pick (
    .cand   (resolved),
    .prio   (core_prio),
    .chosen (lowest)
  );

  assign busy     = |out_q;
  assign send_set = (wr_data[TYPE_LSB +: 3] == DT_LOWEST) ? lowest : resolved;

  always_comb begin
    cmd_d  = cmd_q;
    cmd_en = 1'b0;
    out_d  = out_q & ~ack_i;
    err_d  = err_q;
    if (wr_en) begin
      if (busy || !cmd_ok) begin
        err_d = 1'b1;
      end else begin
        cmd_en = 1'b1;
        cmd_d  = wr_data & KEEP_BITS;
        out_d  = send_set;
        if (send_set == '0) err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cmd_q <= '0;
      out_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (cmd_en) cmd_q <= cmd_d;
      out_q <= out_d;
      err_q <= err_d;
    end
  end

  // outputs
  always_comb begin
    rd_data           = cmd_q;
    rd_data[STAT_BIT] = busy;
  end
  assign req_o     = out_q;
  assign pending_o = busy;
  assign error_o   = err_q;
  assign type_o    = cmd_q[TYPE_LSB +: 3];
  assign vec_o     = (cmd_q[TYPE_LSB +: 3] == DT_NMASK) ? 8'd0 : cmd_q[VEC_LSB +: 8];

  // assertions
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|(req_o & ack_i)) |=> ((req_o & $past(req_o & ack_i)) == '0));

  p_no_new_req_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    pending_o |=> ((req_o & ~$past(req_o)) == '0));

  p_busy_write_err_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && pending_o) |=> error_o);

  p_illegal_no_issue_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && !pending_o && !cmd_ok) |=> (!pending_o && error_o));

  p_lowprio_single_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($rose(pending_o) && (type_o == DT_LOWEST)) |-> ($countones(req_o) == 1));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    error_o |=> error_o);

endmodule

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;

  localparam int N  = 4;
  localparam int PW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [1:0]  self_id = 2'd1;
  logic [31:0] core_lid = {8'h80, 8'h40, 8'h20, 8'h10};
  logic [15:0] core_prio = {4'd7, 4'd3, 4'd3, 4'd5};
  logic [3:0]  req_o;
  logic [3:0]  ack_i = '0;
  logic [7:0]  vec_o;
  logic [2:0]  type_o;
  logic        pending_o;
  logic        error_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ipi_dispatch #(.N_CORES(N), .PRIO_W(PW)) i_ipi_dispatch (
    .clk, .rst_n, .wr_en, .wr_data, .rd_data, .self_id, .core_lid,
    .core_prio, .req_o, .ack_i, .vec_o, .type_o, .pending_o, .error_o
  );

  // ---------------- reference model ----------------
  logic [63:0] m_cmd;
  logic [3:0]  m_out;
  logic        m_err;
  int          rcnt;

  function automatic bit m_legal(logic [63:0] w);
    int t = int'(w[10:8]);
    if (t == 3 || t == 7) return 0;
    if (t == 2 && w[7:0] != 0) return 0;
    if (!w[14] && t != 5) return 0;
    return 1;
  endfunction

  function automatic logic [3:0] m_targets(logic [63:0] w);
    logic [3:0] s = '0;
    int lo = -1;
    for (int c = 0; c < N; c++) begin
      case (int'(w[19:18]))
        0: s[c] = w[11] ? ((w[63:56] & core_lid[8*c +: 8]) != 0) : (int'(w[63:56]) == c);
        1: s[c] = (c == int'(self_id));
        2: s[c] = 1'b1;
        default: s[c] = (c != int'(self_id));
      endcase
    end
    if (w[10:8] == 3'd1) begin
      for (int c = 0; c < N; c++)
        if (s[c] && (lo < 0 || core_prio[4*c +: 4] < core_prio[4*lo +: 4])) lo = c;
      s = '0;
      if (lo >= 0) s[lo] = 1'b1;
    end
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = '0; m_out = '0; m_err = 1'b0; rcnt = 0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      logic [3:0] nxt;
      nxt = m_out & ~ack_i;
      if (wr_en) begin
        if (m_out != 0 || !m_legal(wr_data)) m_err = 1'b1;
        else begin
          m_cmd = {wr_data[63:56], 36'd0, wr_data[19:18], 2'd0, wr_data[15], wr_data[14],
                   1'b0, 1'b0, wr_data[11:0]};
          nxt = m_targets(wr_data);
          if (nxt == 0) m_err = 1'b1;
        end
      end
      m_out = nxt;
    end
  end

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("R5 model req_o", 64'(req_o), 64'(m_out));
      cmp("R7 model pending_o", 64'(pending_o), 64'(m_out != 0));
      cmp("R11 model error_o", 64'(error_o), 64'(m_err));
      cmp("R1 model rd_data", rd_data, m_cmd | (64'(m_out != 0) << 12));
      cmp("R12 model vec_o", 64'(vec_o), (m_cmd[10:8] == 3'd4) ? 64'd0 : 64'(m_cmd[7:0]));
      cmp("R12 model type_o", 64'(type_o), 64'(m_cmd[10:8]));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [63:0] mk(logic [7:0] v, logic [2:0] t, logic dm, logic lvl,
                                      logic [1:0] sh, logic [7:0] d);
    return {d, 36'd0, sh, 2'd0, 1'b0, lvl, 2'b00, dm, t, v};
  endfunction

  task automatic do_write(logic [63:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_ack(logic [3:0] m);
    @(negedge clk); ack_i = m;
    @(negedge clk); ack_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    do_reset();
    cmp("R1 reset rd_data", rd_data, 64'd0);
    cmp("R7 reset pending", 64'(pending_o), 64'd0);
    cmp("R11 reset error", 64'(error_o), 64'd0);

    // R3 physical target 2
    do_write(mk(8'h41, 3'd0, 1'b0, 1'b1, 2'd0, 8'd2));
    cmp("R3 phys req", 64'(req_o), 64'b0100);
    cmp("R12 vec", 64'(vec_o), 64'h41);
    cmp("R1 status bit", 64'(rd_data[12]), 64'd1);
    do_ack(4'b0100);
    cmp("R7 idle after ack", 64'(pending_o), 64'd0);

    // R4 logical mask 0x30 -> cores 0,1; R7 partial accept
    do_write(mk(8'h22, 3'd0, 1'b1, 1'b1, 2'd0, 8'h30));
    cmp("R4 logical req", 64'(req_o), 64'b0011);
    do_ack(4'b0001);
    cmp("R7 still pending", 64'(pending_o), 64'd1);
    cmp("R5 held req", 64'(req_o), 64'b0010);
    do_ack(4'b0010);
    cmp("R7 done", 64'(pending_o), 64'd0);

    // R2 all except self, R8 busy write
    do_write(mk(8'h33, 3'd0, 1'b0, 1'b1, 2'd3, 8'd0));
    cmp("R2 others req", 64'(req_o), 64'b1101);
    do_write(mk(8'h99, 3'd0, 1'b0, 1'b1, 2'd2, 8'd0));
    cmp("R8 error set", 64'(error_o), 64'd1);
    cmp("R8 req unchanged", 64'(req_o), 64'b1101);
    cmp("R8 vector unchanged", 64'(rd_data[7:0]), 64'h33);
    do_ack(4'b1111);
    // R11 error remains across a later good send (self shorthand)
    do_write(mk(8'h34, 3'd0, 1'b0, 1'b1, 2'd1, 8'd0));
    cmp("R2 self req", 64'(req_o), 64'b0010);
    cmp("R11 sticky", 64'(error_o), 64'd1);
    do_ack(4'b0010);
    do_reset();

    // R6 lowest priority, tie -> core1
    do_write(mk(8'h50, 3'd1, 1'b0, 1'b1, 2'd2, 8'd0));
    cmp("R6 tie lowest index", 64'(req_o), 64'b0010);
    do_ack(4'b0010);
    do_write(mk(8'h51, 3'd1, 1'b1, 1'b1, 2'd0, 8'h50));
    cmp("R6 lower prio wins", 64'(req_o), 64'b0100);
    do_ack(4'b0100);
    cmp("R11 clean", 64'(error_o), 64'd0);

    // R9 illegal type 3
    do_write(mk(8'h10, 3'd3, 1'b0, 1'b1, 2'd2, 8'd0));
    cmp("R9 type3 err", 64'(error_o), 64'd1);
    cmp("R9 type3 no req", 64'(req_o), 64'd0);
    cmp("R9 word kept", 64'(rd_data[7:0]), 64'h51);
    do_reset();
    do_write(mk(8'h05, 3'd2, 1'b0, 1'b1, 2'd2, 8'd0));
    cmp("R9 smgmt vec err", 64'(error_o), 64'd1);
    cmp("R9 smgmt no req", 64'(req_o), 64'd0);
    do_reset();
    do_write(mk(8'h00, 3'd2, 1'b0, 1'b1, 2'd2, 8'd0));
    cmp("R9 smgmt vec0 ok", 64'(req_o), 64'b1111);
    do_ack(4'b1111);
    do_write(mk(8'h20, 3'd0, 1'b0, 1'b0, 2'd2, 8'd0));
    cmp("R9 level0 err", 64'(error_o), 64'd1);
    cmp("R9 level0 no req", 64'(req_o), 64'd0);
    do_reset();
    do_write(mk(8'h00, 3'd5, 1'b0, 1'b0, 2'd0, 8'd3));
    cmp("R9 reset-type level0 ok", 64'(req_o), 64'b1000);
    cmp("R9 no error", 64'(error_o), 64'd0);
    do_ack(4'b1000);

    // R10 empty target set
    do_write(mk(8'h20, 3'd0, 1'b0, 1'b1, 2'd0, 8'd9));
    cmp("R10 empty no pending", 64'(pending_o), 64'd0);
    cmp("R10 empty err", 64'(error_o), 64'd1);
    cmp("R10 stored", rd_data, mk(8'h20, 3'd0, 1'b0, 1'b1, 2'd0, 8'd9));
    do_reset();

    // R1 reserved and status bits masked
    do_write(~64'h0 & ~(64'h7 << 8));
    cmp("R1 masked readback", rd_data, 64'hFF00_0000_000C_D8FF);
    cmp("R4 logical all", 64'(req_o), 64'b1101);
    do_ack(4'b1111);

    // R12 non-maskable hides vector
    do_write(mk(8'h77, 3'd4, 1'b0, 1'b1, 2'd1, 8'd0));
    cmp("R12 nmask vec", 64'(vec_o), 64'd0);
    cmp("R12 type", 64'(type_o), 64'd4);
    do_ack(4'b0010);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule